// File: doc/BRIEF.md
# Multithreaded Issue Slot Scheduler

The block decides, on every clock cycle, which of several hardware thread contexts may place an instruction into a shared single-issue pipeline. There are three selection policies. In the fixed rotation, every thread gets one turn in a repeating cycle. In the table-driven policy, software programs a small slot table and the hardware steps through it. In the priority policy, the hardware picks a ready thread by a numeric priority. When the thread that was chosen cannot issue, the block emits a bubble and gives the slot to no other thread.

The chosen thread number travels with each issue down a short shift line, one entry per pipeline stage. Downstream stages use it to index per-thread program counters and register files. The policy is held in a three-state machine with states ST_FIXED, ST_TABLE and ST_PRIO. A mode code of 2'b00 requests ST_FIXED, 2'b01 requests ST_TABLE and 2'b10 requests ST_PRIO; code 2'b11 leaves the state as it is. Any transition into a different state (ST_FIXED to ST_TABLE, ST_TABLE to ST_PRIO, ST_PRIO to ST_FIXED, and the reverse moves) takes effect at the next clock edge. The same edge clears both the rotation pointer and the slot pointer.

Issue outputs are combinational from the current state, the pointers and the ready flags. The stage line is registered.

Top module: `thread_issue_sched`

## Requirements
- R1: In ST_FIXED with every thread ready, the issued thread is 0 in the first cycle after reset or after entry into ST_FIXED, and rises by one each cycle, wrapping from 3 back to 0.
- R2: In ST_FIXED, when the thread whose turn it is has its ready flag low, issue_valid is 0 and issue_bubble is 1, and the rotation still advances.
- R3: In ST_TABLE, slot 0 is used in the first cycle after entry and the slot index rises by one each cycle, wrapping after slot 7. The thread stored in the current slot issues if it is ready; otherwise a bubble is issued.
- R4: A table write (tbl_we high, slot tbl_idx, thread tbl_tid) changes the thread used for that slot only from the next pass through the table onwards. A pass starts when the slot index wraps to 0 or on entry into ST_TABLE. A write never moves the slot index.
- R5: After reset, table slot i holds thread i mod 4.
- R6: In ST_PRIO, the issuing thread is a ready thread with the largest 2-bit priority (thr_prio bits [2t+1:2t] for thread t). A larger value is more urgent. With no thread ready, a bubble is issued.
- R7: In ST_PRIO, equal-priority candidates are searched starting at the thread after the last one issued. The search start is thread 0 on entry into ST_PRIO.
- R8: A mode code 2'b00, 2'b01 or 2'b10 that differs from the current state switches the state at the next edge, and that edge clears both pointers.
- R9: Mode code 2'b11 has no effect: the state and the pointer sequence continue unchanged.
- R10: stg_valid[k] and stg_tid[2k+1:2k] show the valid flag and the thread number issued k+1 cycles earlier, for k = 0..4.
- R11: During an unbroken ST_FIXED run, no thread appears twice among stages 0..3. A thread's previous instruction therefore reaches write-back before its next one reads registers.
- R12: While reset is asserted and directly after it, the state is ST_FIXED, both pointers are 0 and every stage is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Policy request: 00 fixed, 01 table, 10 priority, 11 hold |
| thr_ready | input | 4 | Per-thread ready flags |
| thr_prio | input | 8 | Per-thread 2-bit priorities, thread t at [2t+1:2t] |
| tbl_we | input | 1 | Slot table write strobe |
| tbl_idx | input | 3 | Slot table entry written |
| tbl_tid | input | 2 | Thread number written |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | 2 | Thread selected this cycle |
| issue_bubble | output | 1 | A bubble is inserted this cycle |
| stg_valid | output | 5 | Per-stage valid flag of the thread-number line |
| stg_tid | output | 10 | Per-stage thread numbers, stage k at [2k+1:2k] |

## Verification
Two pairs of events can fall into the same cycle. The first is a table write that lands on the very edge where the slot index wraps. The second is a mode change that lands on the edge where the priority policy would otherwise move its search start. The bench provokes both by pulsing tbl_we at slot 7 and by switching mode in cycles with ready threads. A behavioural model runs beside the block and holds a pending table, a live table and the two pointers as plain integers. Each cycle the bench compares the issue outputs and every stage entry with this model, so that a write visible one pass too early or a pointer left uncleared shows up at once.

// File: rtl/issue_sched_pkg.sv
package issue_sched_pkg;
    typedef enum logic [1:0] {
        ST_FIXED = 2'd0,
        ST_TABLE = 2'd1,
        ST_PRIO  = 2'd2
    } sched_st_e;

    localparam logic [1:0] MODE_FIXED = 2'b00;
    localparam logic [1:0] MODE_TABLE = 2'b01;
    localparam logic [1:0] MODE_PRIO  = 2'b10;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
    parameter int NTHR  = 4,
    parameter int NSLOT = 8,
    localparam int TW   = $clog2(NTHR),
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tid,
    input  logic          load,
    input  logic [SW-1:0] rd_idx,
    output logic [TW-1:0] rd_tid
);
    // Writes land in the pending copy; the live copy only takes them
    // when a new pass begins.
    logic [TW-1:0] pend_q [NSLOT];
    logic [TW-1:0] live_q [NSLOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                pend_q[i] <= TW'(i % NTHR);
                live_q[i] <= TW'(i % NTHR);
            end
        end else begin
            if (load) begin
                for (int i = 0; i < NSLOT; i++) begin
                    live_q[i] <= pend_q[i];
                end
            end
            if (wr_en) begin
                pend_q[wr_idx] <= wr_tid;
            end
        end
    end

    assign rd_tid = live_q[rd_idx];
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int NTHR = 4,
    parameter int PW   = 2,
    localparam int TW  = $clog2(NTHR)
) (
    input  logic [NTHR-1:0]    ready,
    input  logic [NTHR*PW-1:0] prio,
    input  logic [TW-1:0]      start,
    output logic               found,
    output logic [TW-1:0]      pick
);
    logic [TW-1:0] idx;
    logic [PW-1:0] best;

    // Scan from the start thread; a strictly larger value replaces the
    // current choice, so ties go to the earliest thread in scan order.
    always_comb begin
        found = 1'b0;
        pick  = start;
        best  = '0;
        idx   = start;
        for (int i = 0; i < NTHR; i++) begin
            idx = start + TW'(i);
            if (ready[idx] && (!found || (prio[idx*PW +: PW] > best))) begin
                found = 1'b1;
                pick  = idx;
                best  = prio[idx*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/tid_pipe.sv
module tid_pipe #(
    parameter int TW     = 2,
    parameter int STAGES = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [TW-1:0]        in_tid,
    output logic [STAGES-1:0]    out_vld,
    output logic [STAGES*TW-1:0] out_tid
);
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic          src_vld;
        logic [TW-1:0] src_tid;
        if (k == 0) begin : g_head
            assign src_vld = in_vld;
            assign src_tid = in_tid;
        end else begin : g_body
            assign src_vld = out_vld[k-1];
            assign src_tid = out_tid[(k-1)*TW +: TW];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_vld[k]          <= 1'b0;
                out_tid[k*TW +: TW] <= '0;
            end else begin
                out_vld[k]          <= src_vld;
                out_tid[k*TW +: TW] <= src_tid;
            end
        end
    end
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
    import issue_sched_pkg::*;
#(
    parameter int NTHR   = 4,
    parameter int NSLOT  = 8,
    parameter int PW     = 2,
    parameter int STAGES = 5,
    localparam int TW    = $clog2(NTHR),
    localparam int SW    = $clog2(NSLOT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_sel,
    input  logic [NTHR-1:0]      thr_ready,
    input  logic [NTHR*PW-1:0]   thr_prio,
    input  logic                 tbl_we,
    input  logic [SW-1:0]        tbl_idx,
    input  logic [TW-1:0]        tbl_tid,
    output logic                 issue_valid,
    output logic [TW-1:0]        issue_tid,
    output logic                 issue_bubble,
    output logic [STAGES-1:0]    stg_valid,
    output logic [STAGES*TW-1:0] stg_tid
);
    sched_st_e     state_q, state_d;
    logic [TW-1:0] rr_q, rr_d;
    logic [SW-1:0] slot_q, slot_d;
    logic          mode_chg;
    logic [TW-1:0] tbl_rd_tid;
    logic          pr_found;
    logic [TW-1:0] pr_pick;

    // Next-state decode: code 11 keeps the present policy.
    always_comb begin
        unique case (mode_sel)
            MODE_FIXED: state_d = ST_FIXED;
            MODE_TABLE: state_d = ST_TABLE;
            MODE_PRIO:  state_d = ST_PRIO;
            default:    state_d = state_q;
        endcase
        mode_chg = (state_d != state_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FIXED;
            rr_q    <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            rr_q    <= rr_d;
            slot_q  <= slot_d;
        end
    end

    // Outputs of the current state.
    always_comb begin
        unique case (state_q)
            ST_FIXED: begin
                issue_tid   = rr_q;
                issue_valid = thr_ready[rr_q];
            end
            ST_TABLE: begin
                issue_tid   = tbl_rd_tid;
                issue_valid = thr_ready[tbl_rd_tid];
            end
            ST_PRIO: begin
                issue_tid   = pr_pick;
                issue_valid = pr_found;
            end
            default: begin
                issue_tid   = '0;
                issue_valid = 1'b0;
            end
        endcase
        issue_bubble = !issue_valid;
    end

    // Pointer update; a policy switch clears both pointers.
    always_comb begin
        rr_d   = rr_q;
        slot_d = '0;
        if (!mode_chg) begin
            unique case (state_q)
                ST_FIXED: rr_d = rr_q + 1'b1;
                ST_TABLE: slot_d = slot_q + 1'b1;
                ST_PRIO:  if (issue_valid) rr_d = issue_tid + 1'b1;
                default:  rr_d = '0;
            endcase
        end else begin
            rr_d = '0;
        end
    end

    slot_table #(.NTHR(NTHR), .NSLOT(NSLOT)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_idx (tbl_idx),
        .wr_tid (tbl_tid),
        .load   (slot_d == '0),
        .rd_idx (slot_q),
        .rd_tid (tbl_rd_tid)
    );

    prio_pick #(.NTHR(NTHR), .PW(PW)) u_pick (
        .ready (thr_ready),
        .prio  (thr_prio),
        .start (rr_q),
        .found (pr_found),
        .pick  (pr_pick)
    );

    tid_pipe #(.TW(TW), .STAGES(STAGES)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (issue_valid),
        .in_tid  (issue_tid),
        .out_vld (stg_valid),
        .out_tid (stg_tid)
    );
endmodule

// File: rtl/issue_sched_chk.sv
module issue_sched_chk
    import issue_sched_pkg::*;
#(
    parameter int NTHR   = 4,
    parameter int NSLOT  = 8,
    parameter int PW     = 2,
    parameter int STAGES = 5,
    localparam int TW    = $clog2(NTHR),
    localparam int SW    = $clog2(NSLOT)
) (
    input logic                 clk,
    input logic                 rst_n,
    input sched_st_e            state,
    input logic [TW-1:0]        rr_ptr,
    input logic [SW-1:0]        slot_ptr,
    input logic [NTHR-1:0]      thr_ready,
    input logic [NTHR*PW-1:0]   thr_prio,
    input logic                 issue_valid,
    input logic [TW-1:0]        issue_tid,
    input logic [STAGES-1:0]    stg_valid,
    input logic [STAGES*TW-1:0] stg_tid
);
    logic          seen_q;
    sched_st_e     prev_st_q;
    logic [TW-1:0] prev_tid_q;
    logic [2:0]    fix_run_q;
    logic          higher;
    logic          dup;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            prev_st_q  <= ST_FIXED;
            prev_tid_q <= '0;
            fix_run_q  <= '0;
        end else begin
            seen_q     <= 1'b1;
            prev_st_q  <= state;
            prev_tid_q <= issue_tid;
            if (state != ST_FIXED)  fix_run_q <= '0;
            else if (fix_run_q != 3'd7) fix_run_q <= fix_run_q + 3'd1;
        end
    end

    always_comb begin
        higher = 1'b0;
        for (int t = 0; t < NTHR; t++) begin
            if (thr_ready[t] && (thr_prio[t*PW +: PW] > thr_prio[issue_tid*PW +: PW]))
                higher = 1'b1;
        end
    end

    always_comb begin
        dup = 1'b0;
        for (int a = 0; a < NTHR; a++) begin
            for (int b = a + 1; b < NTHR; b++) begin
                if (stg_valid[a] && stg_valid[b] &&
                    (stg_tid[a*TW +: TW] == stg_tid[b*TW +: TW]))
                    dup = 1'b1;
            end
        end
    end

    // R2, R3: an issue never comes from a thread that is not ready
    p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> thr_ready[issue_tid]);

    // R1: fixed rotation advances by one thread per cycle
    p_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && state == ST_FIXED && prev_st_q == ST_FIXED)
        |-> (issue_tid == TW'(prev_tid_q + 1'b1)));

    // R6: no ready thread outranks the issued one
    p_prio_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIO && issue_valid) |-> !higher);

    // R6: priority policy issues whenever someone is ready
    p_prio_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIO && (|thr_ready)) |-> issue_valid);

    // R8: first cycle after a policy switch starts from cleared pointers
    p_switch_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && state != prev_st_q) |-> (rr_ptr == '0 && slot_ptr == '0));

    // R10: stage line shifts issue results
    p_line_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (stg_valid[0] == $past(issue_valid)));

    p_line_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (stg_tid[2*TW-1:TW] == $past(stg_tid[TW-1:0])));

    // R11: no repeated thread in the first stages during a fixed run
    p_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_run_q >= 3'(NTHR)) |-> !dup);
endmodule

bind thread_issue_sched issue_sched_chk #(
    .NTHR(NTHR), .NSLOT(NSLOT), .PW(PW), .STAGES(STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .rr_ptr      (rr_q),
    .slot_ptr    (slot_q),
    .thr_ready   (thr_ready),
    .thr_prio    (thr_prio),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .stg_valid   (stg_valid),
    .stg_tid     (stg_tid)
);

// File: tb/test_thread_issue_sched.sv
module test_thread_issue_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [3:0] thr_ready = 4'hF;
    logic [7:0] thr_prio = 8'h00;
    logic       tbl_we = 1'b0;
    logic [2:0] tbl_idx = 3'd0;
    logic [1:0] tbl_tid = 2'd0;
    logic       issue_valid;
    logic [1:0] issue_tid;
    logic       issue_bubble;
    logic [4:0] stg_valid;
    logic [9:0] stg_tid;

    always #4 clk = ~clk;

    thread_issue_sched i_thread_issue_sched (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .thr_ready(thr_ready),
        .thr_prio(thr_prio), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_tid(tbl_tid),
        .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_bubble(issue_bubble),
        .stg_valid(stg_valid), .stg_tid(stg_tid)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string tag = "R12";
    int unsigned seed = 32'h1234_5678;

    // Behavioural reference state
    int m_state = 0;
    int m_rr = 0;
    int m_slot = 0;
    int m_pend[8];
    int m_live[8];
    int m_sv[5];
    int m_st[5];
    int exp_v, exp_t;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic int rnd(input int range);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) % range);
    endfunction

    task automatic model_expect();
        int best;
        exp_v = 0;
        exp_t = 0;
        if (m_state == 0) begin
            exp_t = m_rr;
            exp_v = thr_ready[m_rr];
        end else if (m_state == 1) begin
            exp_t = m_live[m_slot];
            exp_v = thr_ready[exp_t];
        end else begin
            best = -1;
            for (int i = 0; i < 4; i++) begin
                int c = (m_rr + i) % 4;
                int p = (thr_prio >> (2 * c)) & 3;
                if (thr_ready[c] && p > best) begin
                    best = p;
                    exp_t = c;
                    exp_v = 1;
                end
            end
        end
    endtask

    task automatic model_clock();
        int req;
        req = (mode_sel == 2'b11) ? m_state : int'(mode_sel);
        for (int k = 4; k > 0; k--) begin
            m_sv[k] = m_sv[k-1];
            m_st[k] = m_st[k-1];
        end
        m_sv[0] = exp_v;
        m_st[0] = exp_t;
        if (req != m_state) begin
            m_state = req;
            m_rr = 0;
            m_slot = 0;
        end else if (m_state == 0) begin
            m_rr = (m_rr + 1) % 4;
        end else if (m_state == 1) begin
            m_slot = (m_slot + 1) % 8;
        end else if (exp_v != 0) begin
            m_rr = (exp_t + 1) % 4;
        end
        if (m_slot == 0) begin
            for (int i = 0; i < 8; i++) m_live[i] = m_pend[i];
        end
        if (tbl_we) m_pend[tbl_idx] = int'(tbl_tid);
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic step();
        #1;
        model_expect();
        check(issue_valid == exp_v[0], tag, issue_valid, exp_v);
        check(issue_bubble == !exp_v[0], tag, issue_bubble, !exp_v[0]);
        if (exp_v != 0) check(issue_tid == exp_t[1:0], tag, issue_tid, exp_t);
        for (int k = 0; k < 5; k++) begin
            check(stg_valid[k] == m_sv[k][0], "R10", stg_valid[k], m_sv[k]);
            if (m_sv[k] != 0)
                check(stg_tid[2*k +: 2] == m_st[k][1:0], "R10", stg_tid[2*k +: 2], m_st[k]);
        end
        @(posedge clk);
        model_clock();
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_pend[i] = i % 4;
            m_live[i] = i % 4;
        end
        for (int k = 0; k < 5; k++) begin
            m_sv[k] = 0;
            m_st[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R12: state during reset
        check(stg_valid == 5'b0, "R12", stg_valid, 0);
        check(issue_valid && issue_tid == 2'd0, "R12", issue_tid, 0);
        rst_n = 1'b1;
        tag = "R12";
        step();
        // R1: full rotation, all ready
        tag = "R1";
        repeat (10) step();
        // R2 and R11: bubbles in the fixed rotation
        tag = "R2";
        for (int n = 0; n < 16; n++) begin
            thr_ready = 4'(rnd(16));
            step();
        end
        tag = "R11";
        thr_ready = 4'hF;
        repeat (6) step();
        // R9: code 11 leaves the rotation running
        tag = "R9";
        mode_sel = 2'b11;
        repeat (6) step();
        // R8 then R5: enter the table policy with the reset table
        tag = "R8";
        mode_sel = 2'b01;
        step();
        tag = "R5";
        repeat (9) step();
        // R4: writes mid-pass and on the wrap edge
        tag = "R4";
        for (int n = 0; n < 40; n++) begin
            if (rnd(3) == 0) begin
                tbl_we = 1'b1;
                tbl_idx = 3'(rnd(8));
                tbl_tid = 2'(rnd(4));
            end
            step();
        end
        // R3: table with readiness varying
        tag = "R3";
        for (int n = 0; n < 24; n++) begin
            thr_ready = 4'(rnd(16));
            if (n == 5) begin
                tbl_we = 1'b1;
                tbl_idx = 3'd7;
                tbl_tid = 2'd3;
            end
            step();
        end
        // R8: switch to priority mid-pass
        tag = "R8";
        thr_ready = 4'hF;
        thr_prio = 8'h00;
        mode_sel = 2'b10;
        step();
        // R7: all equal priorities rotate from after the last issue
        tag = "R7";
        repeat (6) step();
        for (int n = 0; n < 12; n++) begin
            thr_ready = 4'(rnd(16));
            step();
        end
        // R6: distinct priorities and no-ready bubbles
        tag = "R6";
        for (int n = 0; n < 40; n++) begin
            thr_ready = 4'(rnd(16));
            thr_prio = 8'(rnd(256));
            step();
        end
        thr_ready = 4'h0;
        step();
        // R9: code 11 inside the priority policy
        tag = "R9";
        mode_sel = 2'b11;
        for (int n = 0; n < 8; n++) begin
            thr_ready = 4'(rnd(16));
            step();
        end
        // R4: write while in priority mode, seen on table entry
        tag = "R4";
        tbl_we = 1'b1;
        tbl_idx = 3'd0;
        tbl_tid = 2'd2;
        step();
        thr_ready = 4'hF;
        mode_sel = 2'b01;
        repeat (10) step();
        // R8: back to fixed, pointer cleared
        tag = "R8";
        mode_sel = 2'b00;
        repeat (3) step();
        tag = "R1";
        repeat (8) step();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule